// File: doc/BRIEF.md
# Host Image Upload Read Port

This block lets a host processor with an 8-bit register bus pull a stored video frame out of frame memory, one pixel at a time. The host sees three byte registers: a control register, a luma data register and a chroma data register. Behind them sits a pixel address counter. The counter walks the frame in raster order: pixel 0 is the top-left pixel, addresses rise left to right, and each line follows the previous one with no gap. The block fetches each pixel from a synchronous frame-memory read port ahead of time and keeps it in a local latch until the host asks for it.

An upload is meaningful only while the display output is frozen and after the host has cleared the counter. A typical upload runs like this. The host freezes the display and writes the counter-clear bit. It polls the busy flag until it drops. It then reads luma followed by chroma for each pixel. The chroma read moves the counter on and starts the fetch of the next pixel. The frame's pixel count comes from the active display mode and is supplied on an input. The host rebuilds the width and height of the image by itself.

Top module: `img_upload_port`

## Requirements
- R1: Register addresses are 0x58 (control), 0x59 (luma) and 0x5A (chroma). A read strobe loads `rd_data` on the clock edge that samples it, and reading any other address returns 0x00.
- R2: Reading the control register returns bit 0 as 0, bit 1 as the `freeze_in` level, bit 2 as the busy flag, and bits 7..3 as 0. After reset it reads 0x00 while `freeze_in` is low.
- R3: Writing the control register with bit 0 set clears the counter to 0 and sets busy. In the following cycle it raises `mem_req` for one cycle with `mem_addr` equal to 0. A control write with bit 0 clear has no effect.
- R4: When `mem_rvalid` returns for the fetch in flight, busy clears and the pixel is latched: luma from `mem_rdata[15:8]` and chroma from `mem_rdata[7:0]`.
- R5: A luma read returns the current pixel's luma and leaves the counter where it is, so repeated luma reads return the same value.
- R6: A chroma read returns the current pixel's chroma, advances the counter by one and starts a fetch of the new address.
- R7: Pixel addresses run 0, 1, 2, … in raster order with no padding at line ends. After the advance from address `frame_len`-1, the counter returns to 0.
- R8: While `freeze_in` is low, luma and chroma reads return 0x00 and the counter does not move.
- R9: While busy is set, luma and chroma reads return 0x00 and the counter does not move.
- R10: A counter clear issued while a fetch is in flight discards that fetch's data, keeps busy set and refetches address 0, so the next pixel read is pixel 0.
- R11: After reset the counter is 0, busy is clear, `rd_data` is 0x00 and `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 8 | Host register address |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| rd_data | output | 8 | Registered host read data |
| freeze_in | input | 1 | High while the display output is frozen |
| frame_len | input | PIX_AW | Pixel count of the current display mode |
| mem_req | output | 1 | One-cycle frame memory read request |
| mem_addr | output | PIX_AW | Pixel address for the request |
| mem_rvalid | input | 1 | Frame memory read data valid |
| mem_rdata | input | 16 | Returned pixel, luma high byte, chroma low byte |

## Verification
The main read path is first driven with a directed raster walk across a short frame. This walk separates correct address order from skipped or repeated pixels, and its step past the last pixel exposes wrap errors. Repeated luma reads tell a non-advancing luma access apart from one that moves the counter. Reads issued straight after a fetch starts, and a clear issued with a fetch in flight, tell apart correct busy gating from stale or lost data. A seeded random mix follows: reads, clears, ignored control writes, freeze toggles, frame length changes and stray addresses. Its pixel values come from an address hash, so any slip of the counter shows up as a data mismatch.

// File: rtl/img_upload_pkg.sv
package img_upload_pkg;

    localparam int DATA_W     = 8;
    localparam int PIX_AW_DEF = 16;

    localparam logic [7:0] ADR_CTRL   = 8'h58;
    localparam logic [7:0] ADR_LUMA   = 8'h59;
    localparam logic [7:0] ADR_CHROMA = 8'h5A;

    // Control register layout, most significant field first.
    typedef struct packed {
        logic [4:0] rsv;
        logic       busy;
        logic       frozen;
        logic       clr;
    } ctrl_reg_t;

    typedef struct packed {
        logic [DATA_W-1:0] luma;
        logic [DATA_W-1:0] chroma;
    } pixel_t;

    // Strobes passed from the register decode to the datapath.
    typedef struct packed {
        logic clr;
        logic adv;
    } host_op_t;

    function automatic logic is_data_reg(input logic [7:0] a);
        return (a == ADR_LUMA) || (a == ADR_CHROMA);
    endfunction

endpackage

// File: rtl/upl_reg_if.sv
module upl_reg_if
    import img_upload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    input  logic              freeze_in,
    input  logic              busy,
    input  pixel_t            pix,
    output host_op_t          op,
    output logic [DATA_W-1:0] rd_data
);

    logic      data_ok;
    ctrl_reg_t ctrl_rd;
    ctrl_reg_t ctrl_wr;
    logic      unused_wbits;

    assign data_ok = freeze_in && !busy;
    assign ctrl_wr = ctrl_reg_t'(host_wdata);
    assign unused_wbits = ^{ctrl_wr.rsv, ctrl_wr.busy, ctrl_wr.frozen};

    always_comb begin
        ctrl_rd        = '0;
        ctrl_rd.busy   = busy;
        ctrl_rd.frozen = freeze_in;
    end

    always_comb begin
        op.clr = host_wr && (host_addr == ADR_CTRL) && ctrl_wr.clr;
        op.adv = host_rd && (host_addr == ADR_CHROMA) && data_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (host_rd) begin
            unique case (host_addr)
                ADR_CTRL:   rd_data <= ctrl_rd;
                ADR_LUMA:   rd_data <= data_ok ? pix.luma   : '0;
                ADR_CHROMA: rd_data <= data_ok ? pix.chroma : '0;
                default:    rd_data <= '0;
            endcase
        end
    end

endmodule

// File: rtl/upl_pix_ctr.sv
module upl_pix_ctr #(
    parameter int PIX_AW = img_upload_pkg::PIX_AW_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    input  logic [PIX_AW-1:0] frame_len,
    output logic [PIX_AW-1:0] cnt
);

    localparam int EXT_W = PIX_AW + 1;

    logic [EXT_W-1:0]  inc_ext;
    logic [PIX_AW-1:0] nxt;

    assign inc_ext = {1'b0, cnt} + EXT_W'(1);
    assign nxt     = (inc_ext >= {1'b0, frame_len}) ? '0 : inc_ext[PIX_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= nxt;
        end
    end

endmodule

// File: rtl/upl_fetch.sv
module upl_fetch
    import img_upload_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   adv,
    input  logic   mem_rvalid,
    input  pixel_t mem_pix,
    output logic   mem_req,
    output logic   busy,
    output pixel_t pix
);

    logic redo;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req <= 1'b0;
            busy    <= 1'b0;
            redo    <= 1'b0;
            pix     <= '0;
        end else begin
            mem_req <= 1'b0;
            if (clr) begin
                if (busy && !mem_rvalid) begin
                    redo <= 1'b1;
                end else begin
                    mem_req <= 1'b1;
                    busy    <= 1'b1;
                    redo    <= 1'b0;
                end
            end else if (adv) begin
                mem_req <= 1'b1;
                busy    <= 1'b1;
            end else if (busy && mem_rvalid) begin
                if (redo) begin
                    mem_req <= 1'b1;
                    redo    <= 1'b0;
                end else begin
                    busy <= 1'b0;
                    pix  <= mem_pix;
                end
            end
        end
    end

endmodule

// File: rtl/img_upload_port.sv
module img_upload_port
    import img_upload_pkg::*;
#(
    parameter int PIX_AW = PIX_AW_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          host_addr,
    input  logic                host_rd,
    input  logic                host_wr,
    input  logic [7:0]          host_wdata,
    output logic [7:0]          rd_data,
    input  logic                freeze_in,
    input  logic [PIX_AW-1:0]   frame_len,
    output logic                mem_req,
    output logic [PIX_AW-1:0]   mem_addr,
    input  logic                mem_rvalid,
    input  logic [2*DATA_W-1:0] mem_rdata
);

    host_op_t          op;
    logic              busy_w;
    pixel_t            pix_w;
    logic [PIX_AW-1:0] cnt_w;

    upl_reg_if u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .freeze_in  (freeze_in),
        .busy       (busy_w),
        .pix        (pix_w),
        .op         (op),
        .rd_data    (rd_data)
    );

    upl_pix_ctr #(.PIX_AW(PIX_AW)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .clr       (op.clr),
        .adv       (op.adv),
        .frame_len (frame_len),
        .cnt       (cnt_w)
    );

    upl_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .clr        (op.clr),
        .adv        (op.adv),
        .mem_rvalid (mem_rvalid),
        .mem_pix    (pixel_t'(mem_rdata)),
        .mem_req    (mem_req),
        .busy       (busy_w),
        .pix        (pix_w)
    );

    assign mem_addr = cnt_w;

endmodule

// File: rtl/img_upload_port_chk.sv
module img_upload_port_chk
    import img_upload_pkg::*;
#(
    parameter int PIX_AW = PIX_AW_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        host_addr,
    input logic              host_rd,
    input logic              host_wr,
    input logic [7:0]        host_wdata,
    input logic [7:0]        rd_data,
    input logic              freeze_in,
    input logic              mem_req,
    input logic [PIX_AW-1:0] mem_addr,
    input logic              busy,
    input logic [PIX_AW-1:0] cnt
);

    logic clr_wr;
    logic data_rd;
    logic unused_chk;

    assign clr_wr     = host_wr && (host_addr == ADR_CTRL) && host_wdata[0];
    assign data_rd    = host_rd && is_data_reg(host_addr);
    assign unused_chk = ^mem_addr;

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr != ADR_CTRL && !is_data_reg(host_addr)) |=> (rd_data == 8'h00));

    p_clear_starts_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> (cnt == '0) && busy);

    p_req_while_busy_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    p_adv_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr_wr && host_rd && host_addr == ADR_CHROMA && freeze_in && !busy)
        |=> (cnt == $past(cnt) + 1'b1) || (cnt == '0));

    p_unfrozen_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !freeze_in) |=> (rd_data == 8'h00));

    p_unfrozen_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!freeze_in && !clr_wr) |=> $stable(cnt));

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !clr_wr) |=> $stable(cnt));

    p_busy_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (data_rd && busy) |=> (rd_data == 8'h00));

endmodule

bind img_upload_port img_upload_port_chk #(.PIX_AW(PIX_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .rd_data    (rd_data),
    .freeze_in  (freeze_in),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .busy       (busy_w),
    .cnt        (cnt_w)
);

// File: tb/img_upload_port_tb.sv
module img_upload_port_tb;

    localparam int AW  = 16;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    host_addr = '0;
    logic          host_rd = 1'b0;
    logic          host_wr = 1'b0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    rd_data;
    logic          freeze_in = 1'b0;
    logic [AW-1:0] frame_len = 16'd15;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid;
    logic [15:0]   mem_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    img_upload_port #(.PIX_AW(AW)) u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .rd_data(rd_data),
        .freeze_in(freeze_in), .frame_len(frame_len), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] exp_luma(input logic [AW-1:0] a);
        logic [15:0] t = a * 16'd37 + 16'd11;
        return t[7:0] ^ t[15:8];
    endfunction

    function automatic logic [7:0] exp_chroma(input logic [AW-1:0] a);
        logic [15:0] t = a * 16'd91 + 16'h5A3;
        return t[7:0] ^ t[13:6];
    endfunction

    function automatic logic [AW-1:0] exp_next(input logic [AW-1:0] c, input logic [AW-1:0] len);
        logic [AW:0] i = {1'b0, c} + 1'b1;
        return (i >= {1'b0, len}) ? '0 : i[AW-1:0];
    endfunction

    // Fixed-latency frame memory model.
    logic [LAT-1:0] vpipe = '0;
    logic [AW-1:0]  apipe [LAT];
    always @(posedge clk) begin
        vpipe    <= {vpipe[LAT-2:0], mem_req};
        apipe[0] <= mem_addr;
        for (int i = 1; i < LAT; i++) apipe[i] <= apipe[i-1];
    end
    assign mem_rvalid = vpipe[LAT-1];
    assign mem_rdata  = {exp_luma(apipe[LAT-1]), exp_chroma(apipe[LAT-1])};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hrd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = rd_data;
    endtask

    task automatic hwr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_wdata = v; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] d;
        bit ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            hrd(8'h58, d);
            if (!d[2]) begin ok = 1'b1; break; end
        end
        check(req, {15'd0, ok}, 16'd1);
    endtask

    task automatic set_freeze(input logic f);
        @(negedge clk);
        freeze_in = f;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]    d;
        logic [AW-1:0] ec;
        logic          frz;
        void'($urandom(32'h00C0FFEE));

        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 rd_data", {8'd0, rd_data}, 16'h0000);
        check("R11 mem_req", {15'd0, mem_req}, 16'h0000);
        check("R11 mem_addr", mem_addr, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        // R2 control read, unfrozen and frozen
        hrd(8'h58, d); check("R2 ctrl unfrozen", {8'd0, d}, 16'h0000);
        set_freeze(1'b1);
        hrd(8'h58, d); check("R2 ctrl frozen", {8'd0, d}, 16'h0002);

        // R1 unmapped addresses
        hrd(8'h57, d); check("R1 addr 57", {8'd0, d}, 16'h0000);
        hrd(8'h5B, d); check("R1 addr 5B", {8'd0, d}, 16'h0000);

        // R3 control write without clear bit has no effect
        hwr(8'h58, 8'hFE);
        check("R3 no clear no req", {15'd0, mem_req}, 16'h0000);
        hrd(8'h58, d); check("R3 no clear not busy", {8'd0, d}, 16'h0002);

        // R3 clear starts fetch of address 0
        hwr(8'h58, 8'h01);
        check("R3 mem_req", {15'd0, mem_req}, 16'h0001);
        check("R3 mem_addr", mem_addr, 16'h0000);
        hrd(8'h58, d); check("R2 busy bit", {8'd0, d}, 16'h0006);
        // R9 data read while busy
        hrd(8'h59, d); check("R9 busy read", {8'd0, d}, 16'h0000);
        wait_idle("R4 busy clears");

        // R4 R5 R6 R7 raster walk across wrap
        ec = '0;
        for (int p = 0; p < 20; p++) begin
            hrd(8'h59, d); check("R4 luma", {8'd0, d}, {8'd0, exp_luma(ec)});
            hrd(8'h59, d); check("R5 luma repeat", {8'd0, d}, {8'd0, exp_luma(ec)});
            hrd(8'h5A, d); check("R6 chroma", {8'd0, d}, {8'd0, exp_chroma(ec)});
            ec = exp_next(ec, frame_len);
            if (p == 14) check("R7 wrap", {15'd0, mem_addr == '0}, 16'h0001);
            hrd(8'h5A, d); check("R9 chroma busy", {8'd0, d}, 16'h0000);
            wait_idle("R7 fetch done");
        end

        // R8 unfrozen reads
        set_freeze(1'b0);
        hrd(8'h59, d); check("R8 luma unfrozen", {8'd0, d}, 16'h0000);
        hrd(8'h5A, d); check("R8 chroma unfrozen", {8'd0, d}, 16'h0000);
        set_freeze(1'b1);
        hrd(8'h59, d); check("R8 counter held", {8'd0, d}, {8'd0, exp_luma(ec)});

        // R10 clear during fetch in flight
        hrd(8'h5A, d); check("R10 chroma pre", {8'd0, d}, {8'd0, exp_chroma(ec)});
        hwr(8'h58, 8'h01);
        hrd(8'h58, d); check("R10 still busy", {8'd0, d}, 16'h0006);
        wait_idle("R10 refetch done");
        ec = '0;
        hrd(8'h59, d); check("R10 luma pixel0", {8'd0, d}, {8'd0, exp_luma(ec)});
        hrd(8'h5A, d); check("R10 chroma pixel0", {8'd0, d}, {8'd0, exp_chroma(ec)});
        ec = exp_next(ec, frame_len);
        wait_idle("R10 next fetch");

        // Seeded random mix
        frz = 1'b1;
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 9);
            case (op)
                0, 1, 2: begin
                    hrd(8'h59, d);
                    check("R5 rnd luma", {8'd0, d}, frz ? {8'd0, exp_luma(ec)} : 16'h0);
                end
                3, 4, 5: begin
                    hrd(8'h5A, d);
                    check("R6 rnd chroma", {8'd0, d}, frz ? {8'd0, exp_chroma(ec)} : 16'h0);
                    if (frz) ec = exp_next(ec, frame_len);
                    wait_idle("R4 rnd idle");
                end
                6: begin
                    hwr(8'h58, 8'(($urandom_range(0, 127) << 1) | 1));
                    ec = '0;
                    wait_idle("R3 rnd clear");
                end
                7: begin
                    frz = ~frz;
                    set_freeze(frz);
                    hrd(8'h58, d);
                    check("R2 rnd freeze bit", {8'd0, d}, {14'd0, frz, 1'b0});
                end
                8: begin
                    logic [7:0] a = 8'($urandom_range(0, 255));
                    if (a == 8'h58 || a == 8'h59 || a == 8'h5A) a = 8'hA5;
                    if ($urandom_range(0, 1) == 1) begin
                        hrd(a, d); check("R1 rnd unmapped", {8'd0, d}, 16'h0000);
                    end else begin
                        hwr(8'h58, 8'($urandom_range(0, 127) << 1));
                    end
                end
                default: begin
                    @(negedge clk);
                    frame_len = 16'($urandom_range(1, 24));
                end
            endcase
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule